// File: doc/BRIEF.md
# Maskable Receiver Error Aggregator

This block sits behind the front end of a digital audio receiver. Every clock cycle the front end presents a vector of error events: parity, biphase coding, confidence, validity, lock loss and two CRC checks. A software-visible mask register decides which of these events count. Each enabled event has four effects. It sets a sticky bit in an error register that clears when read. It asserts a registered combined error output. It raises an interrupt-source level. It can mark the current audio sample for invalidation.

Mask polarity is active-high: a 1 enables a source and a 0 suppresses it. The mask resets to all zeros, so every source is suppressed until software enables it. The two CRC sources are recorded and reported like the other sources. They never mark an audio sample, because a CRC result refers to a whole block and not to the sample in flight. Sample invalidation is decided once per audio-sample strobe. It covers every enabled non-CRC event seen since the previous strobe, including the strobe cycle itself.

Top module: `rx_err_agg`

## Requirements
- R1: The mask register is written when `mask_we_i` is high and reads back on `mask_rdata_o` from the next cycle. Bit 7 is reserved, always reads 0, and ignores writes. After reset the mask is 00h.
- R2: The bit positions are the same in the mask, event and error vectors: 0 parity, 1 biphase, 2 confidence, 3 validity, 4 unlock, 5 channel-status CRC, 6 Q-subcode CRC, 7 reserved. An event on bit 7 has no effect.
- R3: An error-register bit is set in the cycle after an enabled event on that bit. It stays set until a cycle with `err_re_i` high, which clears it. An enabled event in that same read cycle leaves its bit set.
- R4: `rx_err_o` is high in the cycle after any enabled event, and low in the cycle after a cycle that has no enabled event.
- R5: `sample_inv_o` is a one-cycle pulse in the cycle after `sample_stb_i`. It is high only if an enabled event on bits 0..4 occurred between the previous strobe (exclusive) and this strobe (inclusive).
- R6: Events on bits 5 and 6 never raise `sample_inv_o`, even when enabled.
- R7: An event whose mask bit is 0 changes no output: not the error register, `rx_err_o`, `err_irq_o` or `sample_inv_o`.
- R8: `err_irq_o` is high exactly when at least one error-register bit is set.
- R9: A mask write takes effect from the cycle after the write. An event in the write cycle is judged against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Current mask value |
| err_ev_i | input | 8 | Per-cycle error events |
| err_re_i | input | 1 | Error register read strobe (clears on read) |
| err_rdata_o | output | 8 | Latched error register |
| rx_err_o | output | 1 | Registered OR of enabled events |
| err_irq_o | output | 1 | Interrupt source: any latched error |
| sample_stb_i | input | 1 | Audio-sample strobe |
| sample_inv_o | output | 1 | Invalidate pulse for the strobed sample |

## Verification
The bench runs CRC-only events into a strobe. A design that grouped the CRC bits with the other bits would pulse `sample_inv_o` there. It fires an event in the same cycle as a read, and in the same cycle as a mask write. A clear that wins over the set, or a mask applied one cycle early, shows up as a wrong error-register value. An event between two strobes checks that pending state is held and then dropped after the strobe, so a missed or repeated invalidate is caught. Events on bit 7 and on masked bits must leave every output unchanged, which exposes reversed mask polarity.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned ERR_W    = 8;
  localparam int unsigned B_PAR    = 0;
  localparam int unsigned B_BIP    = 1;
  localparam int unsigned B_CONF   = 2;
  localparam int unsigned B_VAL    = 3;
  localparam int unsigned B_UNLK   = 4;
  localparam int unsigned B_CSCRC  = 5;
  localparam int unsigned B_QCRC   = 6;
  localparam int unsigned B_RSV    = 7;
  localparam logic [ERR_W-1:0] RSV_MASK = ERR_W'(1) << B_RSV;
  localparam logic [ERR_W-1:0] CRC_MASK = (ERR_W'(1) << B_CSCRC) | (ERR_W'(1) << B_QCRC);
endpackage

// File: rtl/rx_err_mask.sv
module rx_err_mask #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RSV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & ~RSV;
  end

  assign mask_o = mask_q;

  // R1
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
  // R1
  mask_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & RSV) == '0);
endmodule

// File: rtl/rx_err_latch.sv
module rx_err_latch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RSV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         rd_i,
  output logic [W-1:0] err_o
);
  logic [W-1:0] err_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (RSV[g]) begin : g_rsv
      assign err_q[g] = 1'b0;
    end else begin : g_live
      // set wins over read-clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q[g] <= 1'b0;
        else         err_q[g] <= set_i[g] | (err_q[g] & ~rd_i);
      end
    end
  end

  assign err_o = err_q;

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((err_o & $past(err_o)) == $past(err_o)));
  // R3
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & ~RSV) != '0 |=> (err_o & $past(set_i & ~RSV)) == $past(set_i & ~RSV));
endmodule

// File: rtl/rx_err_inv.sv
module rx_err_inv #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SKIP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         stb_i,
  output logic         inv_o
);
  logic [W-1:0] hit;
  logic [W-1:0] pend_q;
  logic         inv_q;

  assign hit = ev_i & ~SKIP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      inv_q  <= 1'b0;
    end else if (stb_i) begin
      pend_q <= '0;
      inv_q  <= |(pend_q | hit);
    end else begin
      pend_q <= pend_q | hit;
      inv_q  <= 1'b0;
    end
  end

  assign inv_o = inv_q;

  // R5
  inv_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> $past(stb_i));
  // R6
  inv_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && pend_q == '0 && (ev_i & ~SKIP) == '0) |=> !inv_o);
endmodule

// File: rtl/rx_err_agg.sv
module rx_err_agg
  import rx_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [ERR_W-1:0] mask_wdata_i,
  output logic [ERR_W-1:0] mask_rdata_o,
  input  logic [ERR_W-1:0] err_ev_i,
  input  logic             err_re_i,
  output logic [ERR_W-1:0] err_rdata_o,
  output logic             rx_err_o,
  output logic             err_irq_o,
  input  logic             sample_stb_i,
  output logic             sample_inv_o
);
  logic [ERR_W-1:0] mask;
  logic [ERR_W-1:0] en_ev;
  logic [ERR_W-1:0] err_q;
  logic             rx_err_q;

  rx_err_mask #(.W(ERR_W), .RSV(RSV_MASK)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_o(mask)
  );

  // mask high enables a source
  assign en_ev = err_ev_i & mask;

  rx_err_latch #(.W(ERR_W), .RSV(RSV_MASK)) u_latch (
    .clk_i, .rst_ni, .set_i(en_ev), .rd_i(err_re_i), .err_o(err_q)
  );

  rx_err_inv #(.W(ERR_W), .SKIP(CRC_MASK | RSV_MASK)) u_inv (
    .clk_i, .rst_ni, .ev_i(en_ev), .stb_i(sample_stb_i), .inv_o(sample_inv_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_err_q <= 1'b0;
    else         rx_err_q <= |en_ev;
  end

  assign mask_rdata_o = mask;
  assign err_rdata_o  = err_q;
  assign rx_err_o     = rx_err_q;
  assign err_irq_o    = |err_q;

  // R7
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ev_i & mask_rdata_o) == '0 |=> !rx_err_o);
  // R8
  irq_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o == (err_rdata_o != '0));
  // R4
  rx_err_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ev_i & mask_rdata_o) != '0 |=> rx_err_o);
endmodule

// File: tb/rx_err_agg_bench.sv
module rx_err_agg_bench;
  localparam int CLK_PER = 10;

  typedef struct {
    logic [7:0] mask;
    logic [7:0] err;
    logic       rx;
    logic       irq;
    logic       inv;
    string      note;
  } exp_t;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       mask_we_i = 0;
  logic [7:0] mask_wdata_i = '0;
  logic [7:0] mask_rdata_o;
  logic [7:0] err_ev_i = '0;
  logic       err_re_i = 0;
  logic [7:0] err_rdata_o;
  logic       rx_err_o;
  logic       err_irq_o;
  logic       sample_stb_i = 0;
  logic       sample_inv_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t q[$];
  logic [7:0] m_mask = '0, m_err = '0, m_pend = '0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  rx_err_agg u_rx_err_agg (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push the post-edge expectation
  task automatic step(input logic we, input logic [7:0] wd, input logic [7:0] ev,
                      input logic re, input logic stb, input string note);
    exp_t e;
    logic [7:0] en;
    @(negedge clk_i);
    mask_we_i = we; mask_wdata_i = wd; err_ev_i = ev; err_re_i = re; sample_stb_i = stb;
    en = ev & m_mask;
    e.inv = stb ? |((m_pend | en) & 8'h1F) : 1'b0;
    m_pend = stb ? 8'h00 : (m_pend | (en & 8'h1F));
    m_err = (re ? 8'h00 : m_err) | en;
    if (we) m_mask = wd & 8'h7F;
    e.mask = m_mask; e.err = m_err; e.rx = |en; e.irq = |m_err; e.note = note;
    @(posedge clk_i);
    q.push_back(e);
    @(negedge clk_i);
    mask_we_i = 0; err_ev_i = '0; err_re_i = 0; sample_stb_i = 0;
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.note, " R1 mask"}, mask_rdata_o, e.mask);
      chk({e.note, " R3 err"}, err_rdata_o, e.err);
      chk({e.note, " R4 rx_err"}, {7'd0, rx_err_o}, {7'd0, e.rx});
      chk({e.note, " R8 irq"}, {7'd0, err_irq_o}, {7'd0, e.irq});
      chk({e.note, " R5 inv"}, {7'd0, sample_inv_o}, {7'd0, e.inv});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PER * 3);
    chk("R1 reset mask", mask_rdata_o, 8'h00);
    chk("R3 reset err", err_rdata_o, 8'h00);
    chk("R4 reset rx", {7'd0, rx_err_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1;
    // R7: everything suppressed after reset
    step(0, 8'h00, 8'h7F, 0, 1, "R7 masked all");
    step(0, 8'h00, 8'h00, 0, 0, "R7 idle");
    // R9: event in write cycle uses old mask
    step(1, 8'hFF, 8'h01, 0, 0, "R9 write cycle");
    step(0, 8'h00, 8'h00, 1, 0, "R1 read clears");
    // R2: each source separately, strobed
    for (int b = 0; b < 8; b++) begin
      step(0, 8'h00, 8'(1) << b, 0, 0, "R2 single");
      step(0, 8'h00, 8'h00, 0, 1, "R2 strobe");
      step(0, 8'h00, 8'h00, 1, 0, "R2 read");
    end
    // R6: CRC-only event with strobe in same cycle
    step(0, 8'h00, 8'h60, 0, 1, "R6 crc at stb");
    step(0, 8'h00, 8'h00, 0, 0, "R6 idle");
    // R3: read with simultaneous event keeps it
    step(0, 8'h00, 8'h04, 1, 0, "R3 read+set");
    step(0, 8'h00, 8'h00, 0, 0, "R3 sticky");
    step(0, 8'h00, 8'h00, 1, 0, "R3 clear");
    // R5: event then idle then strobe, then second strobe empty
    step(0, 8'h00, 8'h08, 0, 0, "R5 ev");
    step(0, 8'h00, 8'h00, 0, 0, "R5 gap");
    step(0, 8'h00, 8'h00, 0, 1, "R5 stb1");
    step(0, 8'h00, 8'h00, 0, 1, "R5 stb2");
    // R7: selective mask, masked bits ignored
    step(1, 8'h12, 8'h00, 0, 0, "R7 mask 12");
    step(0, 8'h00, 8'hED, 0, 1, "R7 masked ev");
    step(0, 8'h00, 8'h10, 0, 1, "R7 enabled ev");
    step(0, 8'h00, 8'h00, 1, 0, "R8 read");
    step(0, 8'h00, 8'h00, 0, 0, "R8 idle");
    #(CLK_PER * 2);
    finish_run();
  end
endmodule